// File: doc/BRIEF.md
# Multi-Mode SPI Command Sequencer

This block drives a multi-lane SPI shift engine through a short program of commands that together form one message. Software fills up to four command slots. Each slot holds a command word and a byte count. Software also sets how many slots the message uses. When the enable input is raised, the sequencer walks the slots in ascending order. For every byte it issues a one-cycle start strobe to the shift engine. With that strobe it presents the lane width, the lane direction and the data unit size of the active command. It then waits for the engine's byte acknowledge before it issues the next strobe.

Slave select stays asserted from the first command to the last, so a message that mixes widths, such as a single-lane opcode followed by a quad-lane read, reaches the slave as one access. Commands with a zero byte count are passed over. A command with a reserved lane code stops the message and reports an error code that names the failing slot. After the last byte of the last command, the block pulses done and goes quiet. It waits there until the enable input has been dropped and raised again.

Top module: `spi_cmd_seq`

## Requirements
- R1: After reset, `sel_on`, `byte_go` and `msg_done` are low, and `cmd_ptr` and `cmd_err` are zero.
- R2: Register addresses 0 to 3 hold the command words of slots 0 to 3, taken from the low 16 bits of `wr_data`. Addresses 4 to 7 hold the 32-bit byte counts of those slots. Address 8 holds the sequence length in bits [2:0]. Command word fields are: bits [1:0] lane code (00 single, 01 dual, 10 quad, 11 reserved), bit 2 the sample bit, and bits [4:3] the unit code (00 8-bit, 01 16-bit, 10 32-bit). All other command bits have no effect.
- R3: The message runs slots 0 up to the last slot, where the last slot is the sequence length clamped to 3. A sequence length of 0 runs only slot 0.
- R4: A slot with count N produces exactly N `byte_go` pulses, each one cycle long. Each pulse after the first waits for `byte_ack` on the previous byte.
- R5: While `byte_go` is high, `lane_mode` and `unit_sel` show the lane code and unit code of the active slot.
- R6: `lane_rx` is the sample bit for dual and quad slots and is 0 for single-lane slots.
- R7: `sel_on` rises once at the start of a message and stays high without a break until the message ends.
- R8: A slot with a zero count produces no `byte_go` pulse, and the message moves on to the next slot.
- R9: After the last acknowledged byte, `msg_done` is high for exactly one cycle, with `sel_on` low and `cmd_ptr` at 0. No new message starts while the enable input stays high.
- R10: A slot with lane code 11 ends the message without a `byte_go` pulse for that slot and without `msg_done`. It drops `sel_on`, sets `cmd_err` to 4 plus the slot index, and leaves `cmd_ptr` at that slot.
- R11: When `seq_en` is low, from the next cycle on `sel_on` and `byte_go` are low, `cmd_ptr` is 0 and `cmd_err` is 0.
- R12: `cmd_ptr` shows the index of the slot whose bytes are being issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| seq_en | input | 1 | Run enable; low stops and clears the sequencer |
| byte_ack | input | 1 | Shift engine has finished the current byte |
| byte_go | output | 1 | One-cycle strobe that starts one byte |
| lane_mode | output | 2 | Lane code of the active slot |
| lane_rx | output | 1 | Multi-lane phase samples the lanes instead of driving them |
| unit_sel | output | 2 | Data unit code of the active slot |
| sel_on | output | 1 | Slave select asserted |
| msg_done | output | 1 | One-cycle pulse at the end of a message |
| cmd_ptr | output | 3 | Index of the active slot |
| cmd_err | output | 3 | Error code; 0 means no error |

## Verification
Most internal faults in this block show up at the ports within one byte time. A pointer that advances too early or too late changes `cmd_ptr`, `lane_mode` and `unit_sel` on the very next `byte_go` pulse. A wrong byte counter shows as a missing or extra strobe when a slot changes over. A select that drops between slots shows up as a second falling edge of `sel_on` in the same message. A missed abort or a missed stop is visible on the cycle after the offending slot is loaded or after the enable is dropped.

// File: rtl/spi_seq_pkg.sv
// Package: shared types of the command sequencer.
// Assumes the lane and state codes are only compared, never used in arithmetic.
package spi_seq_pkg;

    typedef enum logic [1:0] {
        LANE_X1  = 2'b00,
        LANE_X2  = 2'b01,
        LANE_X4  = 2'b10,
        LANE_BAD = 2'b11
    } lane_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ISSUE,
        ST_WAIT,
        ST_HALT
    } seq_state_e;

    typedef struct packed {
        lane_e      lane;
        logic       rx;
        logic [1:0] unit;
    } cmd_fields_t;

endpackage

// File: rtl/seq_regfile.sv
// Register file: the command words and byte counts of each slot, plus the sequence length.
// Assumes writes are single-cycle strobes; the last-slot index is clamped to the slot count.
module seq_regfile #(
    parameter int NUM_CMD = 4,
    parameter int CMD_W   = 16,
    parameter int LEN_W   = 32,
    parameter int AW      = 4,
    parameter int PTR_W   = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [AW-1:0]                   wr_addr,
    input  logic [LEN_W-1:0]                wr_data,
    output logic [NUM_CMD-1:0][CMD_W-1:0]   cmd_word,
    output logic [NUM_CMD-1:0][LEN_W-1:0]   cmd_len,
    output logic [PTR_W-1:0]                last_idx
);
    localparam int SEQ_ADDR = 2 * NUM_CMD;

    logic [PTR_W-1:0] seq_len_q;

    for (genvar i = 0; i < NUM_CMD; i++) begin : g_slot
        // Holds the command word and byte count of slot i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmd_word[i] <= '0;
                cmd_len[i]  <= '0;
            end else if (wr_en) begin
                if (wr_addr == AW'(i))
                    cmd_word[i] <= wr_data[CMD_W-1:0];
                if (wr_addr == AW'(NUM_CMD + i))
                    cmd_len[i] <= wr_data;
            end
        end
    end

    // Holds the sequence length field.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seq_len_q <= '0;
        else if (wr_en && wr_addr == AW'(SEQ_ADDR))
            seq_len_q <= wr_data[PTR_W-1:0];
    end

    // Clamps the last slot index to the slots that exist.
    always_comb begin
        if (seq_len_q > PTR_W'(NUM_CMD - 1))
            last_idx = PTR_W'(NUM_CMD - 1);
        else
            last_idx = seq_len_q;
    end

endmodule

// File: rtl/cmd_decode.sv
// Command decoder: splits a command word into lane code, sample flag and unit code.
// Assumes the sample bit only applies to multi-lane codes.
module cmd_decode #(
    parameter int CMD_W = 16
) (
    input  logic [CMD_W-1:0]          word,
    output spi_seq_pkg::cmd_fields_t  fields
);
    import spi_seq_pkg::*;

    lane_e lane;

    // Extracts the fields and qualifies the sample flag by lane width.
    always_comb begin
        lane        = lane_e'(word[1:0]);
        fields.lane = lane;
        fields.rx   = word[2] && (lane == LANE_X2 || lane == LANE_X4);
        fields.unit = word[4:3];
    end

endmodule

// File: rtl/seq_ctrl.sv
// Sequencer control: walks the slots, counts bytes, and drives select, strobe, done and error.
// Assumes byte_ack only arrives while a byte is outstanding; other acks are ignored.
module seq_ctrl #(
    parameter int LEN_W = 32,
    parameter int PTR_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   seq_en,
    input  logic                   byte_ack,
    input  spi_seq_pkg::lane_e     cur_lane,
    input  logic [LEN_W-1:0]       cur_len,
    input  logic [PTR_W-1:0]       last_idx,
    output logic [PTR_W-1:0]       ptr,
    output logic                   byte_go,
    output logic                   sel_on,
    output logic                   msg_done,
    output logic [PTR_W-1:0]       cmd_err
);
    import spi_seq_pkg::*;

    localparam logic [PTR_W-1:0] ERR_FLAG = PTR_W'(1) << (PTR_W - 1);

    seq_state_e       state;
    logic [LEN_W-1:0] remain;

    // Runs the slot walk and the byte count of the active slot.
    always_ff @(posedge clk) begin
        if (!rst_n || !seq_en) begin
            state    <= ST_IDLE;
            ptr      <= '0;
            remain   <= '0;
            cmd_err  <= '0;
            msg_done <= 1'b0;
        end else begin
            msg_done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    ptr   <= '0;
                    state <= ST_LOAD;
                end
                ST_LOAD: begin
                    if (cur_lane == LANE_BAD) begin
                        cmd_err <= ERR_FLAG | ptr;
                        state   <= ST_HALT;
                    end else if (cur_len == '0) begin
                        if (ptr == last_idx) begin
                            msg_done <= 1'b1;
                            ptr      <= '0;
                            state    <= ST_HALT;
                        end else begin
                            ptr <= ptr + 1'b1;
                        end
                    end else begin
                        remain <= cur_len;
                        state  <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (byte_ack) begin
                        if (remain == LEN_W'(1)) begin
                            remain <= '0;
                            if (ptr == last_idx) begin
                                msg_done <= 1'b1;
                                ptr      <= '0;
                                state    <= ST_HALT;
                            end else begin
                                ptr   <= ptr + 1'b1;
                                state <= ST_LOAD;
                            end
                        end else begin
                            remain <= remain - 1'b1;
                            state  <= ST_ISSUE;
                        end
                    end
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    // Derives the strobe and select from the state.
    always_comb begin
        byte_go = (state == ST_ISSUE);
        sel_on  = (state == ST_LOAD) || (state == ST_ISSUE) || (state == ST_WAIT);
    end

endmodule

// File: rtl/spi_cmd_seq.sv
// Top: multi-mode SPI command sequencer in front of a shift engine.
// Assumes the engine starts a byte on byte_go and answers each byte with byte_ack.
module spi_cmd_seq #(
    parameter int NUM_CMD = 4,
    parameter int CMD_W   = 16,
    parameter int LEN_W   = 32,
    parameter int AW      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [LEN_W-1:0] wr_data,
    input  logic             seq_en,
    input  logic             byte_ack,
    output logic             byte_go,
    output logic [1:0]       lane_mode,
    output logic             lane_rx,
    output logic [1:0]       unit_sel,
    output logic             sel_on,
    output logic             msg_done,
    output logic [2:0]       cmd_ptr,
    output logic [2:0]       cmd_err
);
    import spi_seq_pkg::*;

    localparam int PTR_W = 3;
    localparam int IDX_W = (NUM_CMD > 1) ? $clog2(NUM_CMD) : 1;

    logic [NUM_CMD-1:0][CMD_W-1:0] cmd_word;
    logic [NUM_CMD-1:0][LEN_W-1:0] cmd_len;
    logic [PTR_W-1:0]              last_idx;
    logic [PTR_W-1:0]              ptr;
    cmd_fields_t                   fields;

    seq_regfile #(
        .NUM_CMD(NUM_CMD), .CMD_W(CMD_W), .LEN_W(LEN_W), .AW(AW), .PTR_W(PTR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmd_word(cmd_word), .cmd_len(cmd_len),
        .last_idx(last_idx)
    );

    cmd_decode #(.CMD_W(CMD_W)) u_dec (
        .word(cmd_word[ptr[IDX_W-1:0]]),
        .fields(fields)
    );

    seq_ctrl #(.LEN_W(LEN_W), .PTR_W(PTR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .byte_ack(byte_ack),
        .cur_lane(fields.lane), .cur_len(cmd_len[ptr[IDX_W-1:0]]),
        .last_idx(last_idx), .ptr(ptr), .byte_go(byte_go),
        .sel_on(sel_on), .msg_done(msg_done), .cmd_err(cmd_err)
    );

    // Presents the active slot's fields to the engine.
    always_comb begin
        lane_mode = fields.lane;
        lane_rx   = fields.rx;
        unit_sel  = fields.unit;
        cmd_ptr   = ptr;
    end

endmodule

// File: rtl/spi_cmd_seq_chk.sv
// Checker: temporal rules of the sequencer ports, bound to every instance of the top.
// Assumes only port-level visibility.
module spi_cmd_seq_chk #(
    parameter int NUM_CMD = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       seq_en,
    input logic       byte_go,
    input logic [1:0] lane_mode,
    input logic       lane_rx,
    input logic       sel_on,
    input logic       msg_done,
    input logic [2:0] cmd_ptr,
    input logic [2:0] cmd_err
);
    AST_GO_UNDER_SEL: assert property (@(posedge clk) disable iff (!rst_n) byte_go |-> sel_on); // R7
    AST_GO_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) byte_go |=> !byte_go); // R4
    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) msg_done |-> (!sel_on && cmd_ptr == 3'd0)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) msg_done |=> !msg_done); // R9
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (cmd_err != 3'd0) |-> (!sel_on && !byte_go && !msg_done)); // R10
    AST_GO_LANE_OK: assert property (@(posedge clk) disable iff (!rst_n) byte_go |-> (lane_mode != 2'b11)); // R10
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !seq_en |=> (!sel_on && !byte_go && cmd_ptr == 3'd0 && cmd_err == 3'd0)); // R11
    AST_RX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (byte_go && lane_mode == 2'b00) |-> !lane_rx); // R6
    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cmd_ptr < 3'(NUM_CMD)); // R12
endmodule

bind spi_cmd_seq spi_cmd_seq_chk #(.NUM_CMD(NUM_CMD)) u_chk (
    .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .byte_go(byte_go),
    .lane_mode(lane_mode), .lane_rx(lane_rx), .sel_on(sel_on),
    .msg_done(msg_done), .cmd_ptr(cmd_ptr), .cmd_err(cmd_err)
);

// File: tb/tb_spi_cmd_seq.sv
// Directed bench: an engine model answers strobes and logs them; one task per scenario.
module tb_spi_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        seq_en = 1'b0;
    logic        byte_ack = 1'b0;
    logic        byte_go;
    logic [1:0]  lane_mode;
    logic        lane_rx;
    logic [1:0]  unit_sel;
    logic        sel_on;
    logic        msg_done;
    logic [2:0]  cmd_ptr;
    logic [2:0]  cmd_err;

    int n_checks = 0;
    int n_fail   = 0;
    int n_go     = 0;
    int n_fall   = 0;
    int n_done   = 0;
    int wait_n   = 0;
    bit prev_sel = 1'b0;
    bit finished = 1'b0;
    int lg_ptr[64];
    int lg_lane[64];
    int lg_rx[64];
    int lg_unit[64];

    spi_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .seq_en(seq_en), .byte_ack(byte_ack),
        .byte_go(byte_go), .lane_mode(lane_mode), .lane_rx(lane_rx),
        .unit_sel(unit_sel), .sel_on(sel_on), .msg_done(msg_done),
        .cmd_ptr(cmd_ptr), .cmd_err(cmd_err)
    );

    always #5 clk = ~clk;

    // Engine model: logs each strobe, acks one cycle later, counts select falls and dones.
    initial begin
        forever begin
            @(negedge clk);
            byte_ack = 1'b0;
            if (byte_go) begin
                if (n_go < 64) begin
                    lg_ptr[n_go]  = int'(cmd_ptr);
                    lg_lane[n_go] = int'(lane_mode);
                    lg_rx[n_go]   = int'(lane_rx);
                    lg_unit[n_go] = int'(unit_sel);
                end
                n_go++;
                wait_n = 1;
            end else if (wait_n > 0) begin
                wait_n--;
                if (wait_n == 0) byte_ack = 1'b1;
            end
            if (prev_sel && !sel_on) n_fall++;
            prev_sel = sel_on;
            if (msg_done) n_done++;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(addr); wr_data = 32'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_log();
        n_go = 0; n_fall = 0; n_done = 0; wait_n = 0;
    endtask

    task automatic run_msg();
        clear_log();
        @(negedge clk);
        seq_en = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (msg_done || cmd_err != 3'd0) break;
        end
    endtask

    task automatic stop_msg();
        @(negedge clk);
        seq_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic chk_go(input int k, input int p, input int l, input int r, input int u, input string tag);
        chk(lg_ptr[k], p, {tag, " ptr"});
        chk(lg_lane[k], l, {tag, " lane"});
        chk(lg_rx[k], r, {tag, " rx"});
        chk(lg_unit[k], u, {tag, " unit"});
    endtask

    task automatic t_reset();
        chk(int'(sel_on), 0, "R1 sel");
        chk(int'(byte_go), 0, "R1 go");
        chk(int'(msg_done), 0, "R1 done");
        chk(int'(cmd_ptr), 0, "R1 ptr");
        chk(int'(cmd_err), 0, "R1 err");
    endtask

    // R3: length 0 runs slot 0 only; R6: sample bit ignored in single-lane mode.
    task automatic t_single();
        wr(8, 0);
        wr(0, 32'h0004);
        wr(4, 3);
        wr(1, 32'h0001);
        wr(5, 5);
        run_msg();
        chk(n_go, 3, "R3 slot0 only byte count");
        for (int k = 0; k < 3; k++) chk_go(k, 0, 0, 0, 0, "R6 single");
        chk(n_done, 1, "R9 done once");
        chk(int'(sel_on), 0, "R9 sel low");
        chk(int'(cmd_ptr), 0, "R9 ptr zero");
        chk(n_fall, 1, "R7 single select fall");
        repeat (20) @(negedge clk);
        chk(n_go, 3, "R9 no restart while enabled");
        stop_msg();
    endtask

    // R2 R3 R4 R5 R8 R12: four slots, mixed widths, slot 2 empty.
    task automatic t_four(input int seqlen, input string tag);
        wr(8, seqlen);
        wr(0, 32'h0000); wr(4, 2);
        wr(1, 32'h000D); wr(5, 1);
        wr(2, 32'h0002); wr(6, 0);
        wr(3, 32'h0016); wr(7, 2);
        run_msg();
        chk(n_go, 5, {tag, " total bytes R4 R8"});
        chk_go(0, 0, 0, 0, 0, {tag, " R5 b0"});
        chk_go(1, 0, 0, 0, 0, {tag, " R5 b1"});
        chk_go(2, 1, 1, 1, 1, {tag, " R12 b2"});
        chk_go(3, 3, 2, 1, 2, {tag, " R8 b3"});
        chk_go(4, 3, 2, 1, 2, {tag, " R2 b4"});
        chk(n_fall, 1, {tag, " R7 select held"});
        chk(n_done, 1, {tag, " R9 done"});
        stop_msg();
    endtask

    // R8: every slot empty, done without strobes.
    task automatic t_all_empty();
        wr(8, 3);
        wr(4, 0); wr(5, 0); wr(6, 0); wr(7, 0);
        wr(0, 0); wr(1, 0); wr(2, 0); wr(3, 0);
        run_msg();
        chk(n_go, 0, "R8 no strobes");
        chk(n_done, 1, "R8 done");
        stop_msg();
    endtask

    // R10: reserved lane in slot 1 aborts; R11: dropping enable clears.
    task automatic t_abort();
        wr(8, 2);
        wr(0, 32'h0000); wr(4, 1);
        wr(1, 32'h0003); wr(5, 4);
        run_msg();
        chk(n_go, 1, "R10 no strobe for bad slot");
        chk(int'(cmd_err), 5, "R10 error code");
        chk(int'(cmd_ptr), 1, "R10 ptr at bad slot");
        chk(int'(sel_on), 0, "R10 select dropped");
        chk(n_done, 0, "R10 no done");
        @(negedge clk);
        seq_en = 1'b0;
        @(negedge clk);
        chk(int'(cmd_err), 0, "R11 error cleared");
        chk(int'(cmd_ptr), 0, "R11 ptr cleared");
        @(negedge clk);
    endtask

    // R11: stop in the middle of a long slot.
    task automatic t_stop();
        int seen;
        wr(8, 0);
        wr(0, 32'h0000); wr(4, 100);
        clear_log();
        @(negedge clk);
        seq_en = 1'b1;
        seen = 0;
        for (int i = 0; i < 200 && seen < 3; i++) begin
            @(negedge clk);
            if (byte_go) seen++;
        end
        seq_en = 1'b0;
        @(negedge clk);
        chk(int'(sel_on), 0, "R11 select low after stop");
        chk(int'(cmd_ptr), 0, "R11 ptr zero after stop");
        seen = n_go;
        repeat (10) @(negedge clk);
        chk(n_go, seen, "R11 no strobes after stop");
        chk(n_done, 0, "R11 no done after stop");
    endtask

    initial begin
        #(10 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_four(3, "seq3");
        t_four(7, "R3 clamp");
        t_all_empty();
        t_abort();
        t_stop();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule